// File: doc/BRIEF.md
# Double-Buffered Four-Channel DAC Code Loader

This block sits between a byte-wide host register port and a four-channel 12-bit digital-to-analog converter. The host assembles a code in a holding buffer with two byte writes. The first write carries the lower eight bits. The second write carries the upper four bits and the number of the channel the code is meant for.

The second write starts a busy window. The window stands for the serial shift of the code into the converter. The outputs do not change at this point. A later read of the high-byte address, made after the busy window has ended, copies the buffered code into the output register of the chosen channel. This lets software stage a value and then release it at a moment it picks.

A status byte reports the converter busy flag. It also reports a busy flag that an external calibration engine drives. Neither the analog converter nor the calibration engine is part of the block.

Top module: `dac_loader`

## Requirements
- R1: After reset, all four channel outputs hold code 0x800 and the status byte reads 0x00.
- R2: A write to address 4 stores data bits 7:0 as bits 7:0 of the buffered code. A write to address 5 stores data bits 3:0 as bits 11:8 of the buffered code.
- R3: On a write to address 5, data bits 7:6 select the target channel (0 to 3), and data bits 5:4 are ignored. Channel n appears on `dacCodes[12n+11:12n]`.
- R4: A write to address 5 sets the converter busy flag (status bit 7) from the next cycle. The flag stays set for BUSY_CYCLES cycles (default 16) and then clears.
- R5: Writing the two bytes alone leaves every output unchanged. A read of address 5 with busy clear copies the buffered code into the selected channel's output in the following cycle.
- R6: A read of address 5 while the converter busy flag is set changes no output.
- R7: A write to address 4 that is not followed by a write to address 5 leaves the busy flag clear.
- R8: A status read (read of address 4) returns the converter busy flag in bit 7 and the calibration busy input in bit 6, with bits 5:0 zero. Reads of other addresses return 0x00.
- R9: A commit changes only the selected channel's output. Every other channel keeps its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Host write strobe, one cycle per access |
| busRe | input | 1 | Host read strobe, one cycle per access |
| busAddr | input | 4 | Host register address |
| busWdata | input | 8 | Host write data |
| busRdata | output | 8 | Host read data, valid in the cycle busRe is high |
| calBusy | input | 1 | Busy flag from the calibration engine |
| dacCodes | output | 48 | Four 12-bit channel output codes, channel 0 in the low bits |

## Verification
A busy counter that is wrong shows up in the status byte at once. It also shows up one cycle after a read of address 5: that read either commits early or misses a commit that should have happened. A holding register or channel field that is wrong stays hidden until a commit. At the commit it appears as a wrong code, or as a change on a channel that was not selected, in the cycle after the read. The bench therefore follows every commit and every refused commit with a compare of all four outputs. It also samples the busy flag in the last cycle of the window and in the first cycle after it.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;
  typedef struct packed {
    logic loadLow;
    logic loadHigh;
    logic commit;
  } dacStrobes_t;
endpackage

// File: rtl/dac_loader_ctrl.sv
module dac_loader_ctrl
  import dac_loader_pkg::*;
#(
  parameter int BUSY_CYCLES = 16,
  parameter logic [3:0] ADDR_LOW = 4'd4,
  parameter logic [3:0] ADDR_HIGH = 4'd5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWe,
  input  logic        busRe,
  input  logic [3:0]  busAddr,
  output dacStrobes_t strb,
  output logic        dacBusy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] busyCnt;

  assign dacBusy = (busyCnt != '0);

  always_comb begin
    strb.loadLow  = busWe && (busAddr == ADDR_LOW);
    strb.loadHigh = busWe && (busAddr == ADDR_HIGH);
    strb.commit   = busRe && (busAddr == ADDR_HIGH) && !dacBusy;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyCnt <= '0;
    end else if (strb.loadHigh) begin
      busyCnt <= CNT_W'(BUSY_CYCLES);
    end else if (busyCnt != '0) begin
      busyCnt <= busyCnt - 1'b1;
    end
  end

  // R4: a high-byte write raises busy in the next cycle
  a_r4_busy_rises: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_HIGH) |=> dacBusy);

  // R7: a low-byte write on its own never starts a transfer
  a_r7_low_no_busy: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && busAddr == ADDR_LOW && !dacBusy) |=> !dacBusy);
endmodule

// File: rtl/dac_loader_dp.sv
module dac_loader_dp
  import dac_loader_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int NUM_CH = 4,
  parameter logic [3:0] ADDR_LOW = 4'd4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dacStrobes_t              strb,
  input  logic                     dacBusy,
  input  logic                     calBusy,
  input  logic                     busRe,
  input  logic [3:0]               busAddr,
  input  logic [7:0]               busWdata,
  output logic [7:0]               busRdata,
  output logic [NUM_CH*CODE_W-1:0] dacCodes
);
  localparam int CH_W = $clog2(NUM_CH);
  localparam int HI_W = CODE_W - 8;
  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1) << (CODE_W - 1);

  logic [CODE_W-1:0] holdCode;
  logic [CH_W-1:0]   holdChan;
  logic [CODE_W-1:0] codeReg [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCode <= '0;
      holdChan <= '0;
    end else begin
      if (strb.loadLow)  holdCode[7:0] <= busWdata;
      if (strb.loadHigh) begin
        holdCode[CODE_W-1:8] <= busWdata[HI_W-1:0];
        holdChan             <= busWdata[7 -: CH_W];
      end
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk) begin
      if (!rstN) codeReg[ch] <= MID_CODE;
      else if (strb.commit && holdChan == CH_W'(ch)) codeReg[ch] <= holdCode;
    end
    assign dacCodes[ch*CODE_W +: CODE_W] = codeReg[ch];
  end

  always_comb begin
    busRdata = 8'h00;
    if (busRe && busAddr == ADDR_LOW) busRdata = {dacBusy, calBusy, 6'b0};
  end

  // R6 / R9: outputs move only on a commit strobe
  a_r6_outputs_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(dacCodes));

  // R5: a commit lands the buffered code on the buffered channel
  a_r5_commit_lands: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> dacCodes[$past(holdChan)*CODE_W +: CODE_W] == $past(holdCode));
endmodule

// File: rtl/dac_loader.sv
module dac_loader
  import dac_loader_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int NUM_CH = 4,
  parameter int BUSY_CYCLES = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busWe,
  input  logic                     busRe,
  input  logic [3:0]               busAddr,
  input  logic [7:0]               busWdata,
  output logic [7:0]               busRdata,
  input  logic                     calBusy,
  output logic [NUM_CH*CODE_W-1:0] dacCodes
);
  localparam logic [3:0] ADDR_LOW  = 4'd4;
  localparam logic [3:0] ADDR_HIGH = 4'd5;

  dacStrobes_t strb;
  logic        dacBusy;

  dac_loader_ctrl #(
    .BUSY_CYCLES(BUSY_CYCLES), .ADDR_LOW(ADDR_LOW), .ADDR_HIGH(ADDR_HIGH)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .strb(strb), .dacBusy(dacBusy)
  );

  dac_loader_dp #(
    .CODE_W(CODE_W), .NUM_CH(NUM_CH), .ADDR_LOW(ADDR_LOW)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dacBusy(dacBusy),
    .calBusy(calBusy), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .dacCodes(dacCodes)
  );
endmodule

// File: tb/test_dac_loader.sv
module test_dac_loader;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic        calBusy = 1'b0;
  logic [47:0] dacCodes;

  dac_loader #(.BUSY_CYCLES(BUSY)) i_dac_loader (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .calBusy(calBusy), .dacCodes(dacCodes)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    string       req;
    logic [47:0] outs;
    bit          chkRd;
    logic [7:0]  rd;
  } expItem_t;

  expItem_t    sbq[$];
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  logic [11:0] expOut [4];

  function automatic logic [47:0] packOuts();
    return {expOut[3], expOut[2], expOut[1], expOut[0]};
  endfunction

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      wait (sbq.size() != 0);
      begin
        expItem_t it;
        it = sbq.pop_front();
        checks++;
        if (dacCodes !== it.outs) begin
          failures++;
          $display("FAIL %s outputs actual=%h expected=%h", it.req, dacCodes, it.outs);
        end
        if (it.chkRd) begin
          checks++;
          if (busRdata !== it.rd) begin
            failures++;
            $display("FAIL %s rdata actual=%h expected=%h", it.req, busRdata, it.rd);
          end
        end
      end
    end
  end

  task automatic push(string req, bit chkRd, logic [7:0] rd);
    expItem_t it;
    it.req = req; it.outs = packOuts(); it.chkRd = chkRd; it.rd = rd;
    sbq.push_back(it);
  endtask

  task automatic busWrite(logic [3:0] a, logic [7:0] d);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [3:0] a, string req, bit chkRd, logic [7:0] rd);
    busRe = 1'b1; busAddr = a;
    #1 if (chkRd) push(req, 1'b1, rd);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic chkOuts(string req);
    #1 push(req, 1'b0, 8'h00);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 4; i++) expOut[i] = 12'h800;
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R1 reset values
    chkOuts("R1");
    busRead(4'd4, "R1", 1'b1, 8'h00);

    // R2 R3 R5: stage code 0xABC for channel 2, bits 5:4 set and ignored
    busWrite(4'd4, 8'hBC);
    busWrite(4'd5, {2'd2, 2'b11, 4'hA});
    chkOuts("R5 write alone leaves outputs");
    // R4 busy window
    busRead(4'd4, "R4 busy after high write", 1'b1, 8'h80);
    idle(BUSY - 2);
    busRead(4'd4, "R4 busy in last cycle", 1'b1, 8'h80);
    busRead(4'd4, "R4 busy cleared", 1'b1, 8'h00);
    busRead(4'd5, "", 1'b0, 8'h00);
    expOut[2] = 12'hABC;
    chkOuts("R2 R3 commit ch2");

    // R6: read while busy is refused
    busWrite(4'd4, 8'h34);
    busWrite(4'd5, {2'd1, 2'b00, 4'h5});
    busRead(4'd5, "", 1'b0, 8'h00);
    chkOuts("R6 commit refused while busy");
    idle(BUSY);
    busRead(4'd5, "", 1'b0, 8'h00);
    expOut[1] = 12'h534;
    chkOuts("R5 commit after busy");

    // R7: low byte only
    busWrite(4'd4, 8'h77);
    busRead(4'd4, "R7 no busy from low byte", 1'b1, 8'h00);
    idle(3);
    busRead(4'd4, "R7 still idle", 1'b1, 8'h00);

    // R8: status composition and other addresses
    calBusy = 1'b1;
    busRead(4'd4, "R8 cal busy bit", 1'b1, 8'h40);
    busWrite(4'd5, {2'd0, 2'b00, 4'h1});
    busRead(4'd4, "R8 both busy", 1'b1, 8'hC0);
    busRead(4'd3, "R8 other address", 1'b1, 8'h00);
    busRead(4'd5, "R8 high address reads zero", 1'b1, 8'h00);
    calBusy = 1'b0;
    idle(BUSY);

    // R9: each channel in turn, others untouched
    for (int ch = 0; ch < 4; ch++) begin
      logic [11:0] code;
      code = 12'h111 * (ch + 3);
      busWrite(4'd4, code[7:0]);
      busWrite(4'd5, {2'(ch), 2'b01, code[11:8]});
      idle(BUSY);
      busRead(4'd5, "", 1'b0, 8'h00);
      expOut[ch] = code;
      chkOuts("R9 only selected channel");
    end
    // R5 repeat commit of same buffer changes nothing
    busRead(4'd5, "", 1'b0, 8'h00);
    chkOuts("R5 recommit same value");

    idle(2);
    wait (sbq.size() == 0);
    #1 finishRun();
  end
endmodule